// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the home-node directory for a distributed shared-memory machine with `NODES` processors. For every memory block it keeps a coherence state (Uncached, Shared or Exclusive), a full bit-vector of the nodes that hold a copy, and the block's data word. Caches send it three kinds of request: read miss, write miss and write-back. It answers on one outgoing message channel with data replies, invalidations, fetches and fetch-with-invalidate commands.

When a block is Exclusive, the only valid copy sits in the owner's cache. A miss to such a block sends a fetch to the owner and marks the block busy. The owner answers on a separate data-return channel. The directory then writes the returned word into its memory and forwards it to the waiting requester. While the block is busy, any request to it gets a retry message and has no other effect. Only one transaction is in flight at a time per block. Requests to other blocks proceed normally while a block waits.

All three channels use valid/ready handshakes, and a transfer happens on a clock edge where both are high. A sender keeps valid high and its fields unchanged until the transfer. The directory works on one command at a time. While it is still emitting messages for a command, it drops `req_ready` and `rsp_ready`. An owner data return takes priority over a request offered in the same cycle. The message channel accepts back-pressure from `msg_ready` on every message.

Top module: `coh_dir_home`

## Requirements
- R1: After reset every block is Uncached, holds no sharers and is not busy. Block `b` holds data `3*b+1` (truncated to DW bits). No message is valid, and `req_ready` and `rsp_ready` are high.
- R2: A read miss (kind 0) to an Uncached block produces a data reply (type 0) with the memory word to the requester. The block becomes Shared with the requester as its only sharer.
- R3: A write miss (kind 1) to an Uncached block produces a data reply with the memory word. The block becomes Exclusive, owned by the requester.
- R4: A read miss to a Shared block produces a data reply with the memory word and adds the requester to the sharer set.
- R5: A write miss to a Shared block sends an invalidate (type 1, data 0) to every sharer except the requester, then a data reply to the requester. The requester becomes the sole owner in Exclusive.
- R6: A read miss to an Exclusive block sends a fetch (type 2, data 0) to the owner and makes the block busy. The owner's returned word is written to memory and sent as a data reply to the requester. The block then becomes Shared with both the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-invalidate (type 3, data 0) to the owner and makes the block busy. The returned word is written to memory and sent to the requester, which becomes the sole owner in Exclusive.
- R8: A write-back (kind 2) from the owner of an Exclusive block writes its data to memory, clears the sharers and makes the block Uncached, with no message. A write-back from any other node, or a request of kind 3, changes nothing and sends nothing.
- R9: Any request to a busy block produces a retry message (type 4, data 0) to the requester and leaves the block's state, sharers, memory and pending transaction unchanged.
- R10: While `msg_valid` is high and `msg_ready` is low, the message stays valid and its type, destination, address and data do not change.
- R11: The messages for one command carry that command's block address. Invalidates go out in ascending node order and the data reply or command message comes last. No further message follows until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Directory can take a request this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 no-op |
| req_src | input | clog2(NODES) | Requesting node |
| req_addr | input | clog2(BLOCKS) | Block index |
| req_data | input | DW | Write-back data |
| rsp_valid | input | 1 | Owner data return offered |
| rsp_ready | output | 1 | Directory can take a data return |
| rsp_addr | input | clog2(BLOCKS) | Block the data belongs to |
| rsp_data | input | DW | Returned block data |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Receiver takes the message |
| msg_type | output | 3 | 0 data, 1 invalidate, 2 fetch, 3 fetch-invalidate, 4 retry |
| msg_dst | output | clog2(NODES) | Destination node |
| msg_addr | output | clog2(BLOCKS) | Block index |
| msg_data | output | DW | Data word (zero except on data replies) |

## Verification
A wrong sharer vector has no port of its own, so it shows up only at the next write miss to that block. There it appears as a missing, extra or misordered invalidate, or as a fetch aimed at the wrong node. A stale memory word shows up at the next data reply from a non-Exclusive block. The bench therefore follows each state change with a write miss or read miss soon after, within a few commands. A busy flag that is stuck or lost shows up at once as a retry where a reply was due, or as a reply where a retry was due.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    DIR_UNC = 2'd0,
    DIR_SH  = 2'd1,
    DIR_EX  = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_WBACK = 2'd2,
    RQ_NOP   = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    MSG_DATA  = 3'd0,
    MSG_INV   = 3'd1,
    MSG_FETCH = 3'd2,
    MSG_FINV  = 3'd3,
    MSG_RETRY = 3'd4
  } msg_type_e;

endpackage

// File: rtl/coh_dir_table.sv
module coh_dir_table
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DW     = 16,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  output dir_state_e       e_state,
  output logic [NODES-1:0] e_sh,
  output logic [DW-1:0]    e_data,
  output logic             e_busy,
  output logic [NW-1:0]    e_preq,
  output logic             e_pwr,
  input  logic             wr_en,
  input  dir_state_e       n_state,
  input  logic [NODES-1:0] n_sh,
  input  logic             n_busy,
  input  logic [NW-1:0]    n_preq,
  input  logic             n_pwr,
  input  logic             mem_we,
  input  logic [DW-1:0]    mem_wd
);

  dir_state_e       st_q   [BLOCKS];
  logic [NODES-1:0] sh_q   [BLOCKS];
  logic [DW-1:0]    mem_q  [BLOCKS];
  logic             busy_q [BLOCKS];
  logic [NW-1:0]    preq_q [BLOCKS];
  logic             pwr_q  [BLOCKS];

  assign e_state = st_q[addr];
  assign e_sh    = sh_q[addr];
  assign e_data  = mem_q[addr];
  assign e_busy  = busy_q[addr];
  assign e_preq  = preq_q[addr];
  assign e_pwr   = pwr_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLOCKS; i++) begin
        st_q[i]   <= DIR_UNC;
        sh_q[i]   <= '0;
        mem_q[i]  <= DW'(3 * i + 1);
        busy_q[i] <= 1'b0;
        preq_q[i] <= '0;
        pwr_q[i]  <= 1'b0;
      end
    end else begin
      if (wr_en) begin
        st_q[addr]   <= n_state;
        sh_q[addr]   <= n_sh;
        busy_q[addr] <= n_busy;
        preq_q[addr] <= n_preq;
        pwr_q[addr]  <= n_pwr;
      end
      if (mem_we) mem_q[addr] <= mem_wd;
    end
  end

  for (genvar b = 0; b < BLOCKS; b++) begin : g_inv
    // R3
    ex_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == DIR_EX) |-> $onehot(sh_q[b]));
    // R8
    unc_no_sharer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == DIR_UNC) |-> (sh_q[b] == '0));
    // R4
    sh_has_sharer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == DIR_SH) |-> (sh_q[b] != '0));
    // R9
    busy_only_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[b] |-> (st_q[b] == DIR_EX));
  end

endmodule

// File: rtl/coh_dir_sender.sv
module coh_dir_sender
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DW     = 16,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NODES-1:0] ld_inv,
  input  logic [AW-1:0]    ld_addr,
  input  msg_type_e        ld_type,
  input  logic [NW-1:0]    ld_dst,
  input  logic [DW-1:0]    ld_data,
  output logic             busy,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [2:0]       msg_type,
  output logic [NW-1:0]    msg_dst,
  output logic [AW-1:0]    msg_addr,
  output logic [DW-1:0]    msg_data
);

  logic [NODES-1:0] inv_q;
  logic             fin_q;
  msg_type_e        type_q;
  logic [NW-1:0]    dst_q;
  logic [DW-1:0]    data_q;
  logic [AW-1:0]    addr_q;
  logic [NW-1:0]    lo_idx;
  logic             inv_pend;

  always_comb begin
    lo_idx = '0;
    for (int i = NODES - 1; i >= 0; i--) if (inv_q[i]) lo_idx = NW'(i);
  end

  assign inv_pend  = |inv_q;
  assign msg_valid = inv_pend | fin_q;
  assign busy      = msg_valid;
  assign msg_type  = inv_pend ? MSG_INV : type_q;
  assign msg_dst   = inv_pend ? lo_idx : dst_q;
  assign msg_addr  = addr_q;
  assign msg_data  = inv_pend ? '0 : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q  <= '0;
      fin_q  <= 1'b0;
      type_q <= MSG_DATA;
      dst_q  <= '0;
      data_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      inv_q  <= ld_inv;
      fin_q  <= 1'b1;
      type_q <= ld_type;
      dst_q  <= ld_dst;
      data_q <= ld_data;
      addr_q <= ld_addr;
    end else if (msg_valid && msg_ready) begin
      if (inv_pend) inv_q <= inv_q & (inv_q - 1'b1);
      else          fin_q <= 1'b0;
    end
  end

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type) && $stable(msg_dst)
                                   && $stable(msg_addr) && $stable(msg_data)));
  // R11
  final_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_type != MSG_INV) |=> !msg_valid);
  // R11
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !msg_valid);

endmodule

// File: rtl/coh_dir_home.sv
module coh_dir_home
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DW     = 16,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [NW-1:0] req_src,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [AW-1:0] rsp_addr,
  input  logic [DW-1:0] rsp_data,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [2:0]    msg_type,
  output logic [NW-1:0] msg_dst,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);

  logic             snd_busy, take_rsp, take_req;
  logic [AW-1:0]    sel_addr;
  dir_state_e       e_state, n_state;
  logic [NODES-1:0] e_sh, n_sh, me, pend_bit;
  logic [DW-1:0]    e_data, mem_wd, f_data;
  logic             e_busy, n_busy, e_pwr, n_pwr, wr_en, mem_we, ld;
  logic [NW-1:0]    e_preq, n_preq, owner, f_dst;
  logic [NODES-1:0] ld_inv;
  msg_type_e        f_type;

  assign rsp_ready = !snd_busy;
  assign req_ready = !snd_busy && !rsp_valid;
  assign take_rsp  = rsp_valid && rsp_ready;
  assign take_req  = req_valid && req_ready;
  assign sel_addr  = rsp_valid ? rsp_addr : req_addr;

  always_comb begin
    me = '0;
    me[req_src] = 1'b1;
    pend_bit = '0;
    pend_bit[e_preq] = 1'b1;
    owner = '0;
    for (int i = NODES - 1; i >= 0; i--) if (e_sh[i]) owner = NW'(i);
  end

  always_comb begin
    wr_en = 1'b0; mem_we = 1'b0; mem_wd = req_data; ld = 1'b0; ld_inv = '0;
    n_state = e_state; n_sh = e_sh; n_busy = e_busy; n_preq = e_preq; n_pwr = e_pwr;
    f_type = MSG_DATA; f_dst = req_src; f_data = e_data;
    if (take_rsp) begin
      if (e_busy) begin
        wr_en = 1'b1; mem_we = 1'b1; mem_wd = rsp_data; n_busy = 1'b0;
        ld = 1'b1; f_dst = e_preq; f_data = rsp_data;
        if (e_pwr) begin n_state = DIR_EX; n_sh = pend_bit; end
        else       begin n_state = DIR_SH; n_sh = e_sh | pend_bit; end
      end
    end else if (take_req) begin
      if (e_busy) begin
        ld = 1'b1; f_type = MSG_RETRY; f_data = '0;
      end else begin
        case (req_kind_e'(req_kind))
          RQ_READ, RQ_WRITE: begin
            wr_en = 1'b1; ld = 1'b1;
            if (e_state == DIR_EX) begin
              n_busy = 1'b1; n_preq = req_src; n_pwr = (req_kind == RQ_WRITE);
              f_type = (req_kind == RQ_WRITE) ? MSG_FINV : MSG_FETCH;
              f_dst = owner; f_data = '0;
            end else if (req_kind == RQ_READ) begin
              n_state = DIR_SH;
              n_sh = ((e_state == DIR_SH) ? e_sh : '0) | me;
            end else begin
              ld_inv = (e_state == DIR_SH) ? (e_sh & ~me) : '0;
              n_state = DIR_EX; n_sh = me;
            end
          end
          RQ_WBACK: begin
            if (e_state == DIR_EX && e_sh == me) begin
              wr_en = 1'b1; mem_we = 1'b1; n_state = DIR_UNC; n_sh = '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  coh_dir_table #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) u_table (
    .clk(clk), .rst_n(rst_n), .addr(sel_addr),
    .e_state(e_state), .e_sh(e_sh), .e_data(e_data), .e_busy(e_busy),
    .e_preq(e_preq), .e_pwr(e_pwr),
    .wr_en(wr_en), .n_state(n_state), .n_sh(n_sh), .n_busy(n_busy),
    .n_preq(n_preq), .n_pwr(n_pwr), .mem_we(mem_we), .mem_wd(mem_wd)
  );

  coh_dir_sender #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) u_sender (
    .clk(clk), .rst_n(rst_n), .load(ld), .ld_inv(ld_inv), .ld_addr(sel_addr),
    .ld_type(f_type), .ld_dst(f_dst), .ld_data(f_data), .busy(snd_busy),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
    .msg_dst(msg_dst), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // R9
  retry_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && e_busy) |=> (msg_valid && msg_type == MSG_RETRY && msg_dst == $past(req_src)));
  // R5
  no_self_invalidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && !e_busy && req_kind == RQ_WRITE && e_state == DIR_SH)
      |=> !(msg_valid && msg_type == MSG_INV && msg_dst == $past(req_src)));
  // R6
  rsp_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_rsp && e_busy) |=> (msg_valid && msg_type == MSG_DATA && msg_data == $past(rsp_data)));

endmodule

// File: tb/coh_dir_home_test.sv
module coh_dir_home_test;
  localparam int NODES = 4, BLOCKS = 4, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_valid = 1'b0, msg_ready = 1'b1;
  logic [1:0] req_kind = '0, req_src = '0, req_addr = '0, rsp_addr = '0;
  logic [7:0] req_data = '0, rsp_data = '0;
  logic req_ready, rsp_ready, msg_valid;
  logic [2:0] msg_type;
  logic [1:0] msg_dst, msg_addr;
  logic [7:0] msg_data;

  always #10 clk = ~clk;

  coh_dir_home #(.NODES(NODES), .BLOCKS(BLOCKS), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type), .msg_dst(msg_dst),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of the directory, driven from the requirements
  int m_st[BLOCKS], m_sh[BLOCKS], m_mem[BLOCKS], m_busy[BLOCKS], m_preq[BLOCKS], m_pwr[BLOCKS];
  int q_t[8], q_d[8], q_v[8];
  string q_tag[8];
  int q_n;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int t, input int d, input int v, input string tag);
    q_t[q_n] = t; q_d[q_n] = d; q_v[q_n] = v; q_tag[q_n] = tag; q_n++;
  endtask

  function automatic int owner_of(input int sh);
    for (int i = 0; i < NODES; i++) if (sh[i]) return i;
    return 0;
  endfunction

  task automatic expect_msgs(input int a, input int stall);
    for (int k = 0; k < q_n; k++) begin
      int w = 0;
      int exp, act;
      while (!msg_valid && w < 20) begin @(negedge clk); w++; end
      exp = (q_t[k] << 16) | (q_d[k] << 12) | (a << 8) | (q_v[k] & 8'hFF);
      act = (int'(msg_type) << 16) | (int'(msg_dst) << 12) | (int'(msg_addr) << 8) | int'(msg_data);
      chk(msg_valid && act == exp, q_tag[k], act, exp);
      if (stall > 0 && k == 0) begin
        msg_ready = 1'b0;
        for (int s = 0; s < stall; s++) @(negedge clk);
        act = (int'(msg_type) << 16) | (int'(msg_dst) << 12) | (int'(msg_addr) << 8) | int'(msg_data);
        chk(msg_valid && act == exp, "R10 held under back-pressure", act, exp);
        msg_ready = 1'b1;
      end
      @(negedge clk);
    end
    chk(!msg_valid, "R11 no extra message", int'(msg_valid), 0);
  endtask

  task automatic do_req(input int kind, input int src, input int a, input int d, input int stall);
    int bit_s = 1 << src;
    q_n = 0;
    if (m_busy[a] != 0) push(4, src, 0, "R9 retry");
    else if (kind == 0) begin
      if (m_st[a] == 2) begin
        push(2, owner_of(m_sh[a]), 0, "R6 fetch");
        m_busy[a] = 1; m_preq[a] = src; m_pwr[a] = 0;
      end else begin
        push(0, src, m_mem[a], (m_st[a] == 1) ? "R4 read shared" : "R2 read uncached");
        m_sh[a] = ((m_st[a] == 1) ? m_sh[a] : 0) | bit_s; m_st[a] = 1;
      end
    end else if (kind == 1) begin
      if (m_st[a] == 2) begin
        push(3, owner_of(m_sh[a]), 0, "R7 fetch-invalidate");
        m_busy[a] = 1; m_preq[a] = src; m_pwr[a] = 1;
      end else begin
        if (m_st[a] == 1)
          for (int n = 0; n < NODES; n++)
            if (m_sh[a][n] && n != src) push(1, n, 0, "R5 R11 invalidate");
        push(0, src, m_mem[a], (m_st[a] == 1) ? "R5 write shared" : "R3 write uncached");
        m_st[a] = 2; m_sh[a] = bit_s;
      end
    end else if (kind == 2) begin
      if (m_st[a] == 2 && m_sh[a] == bit_s) begin
        m_mem[a] = d; m_st[a] = 0; m_sh[a] = 0;
      end
    end
    req_kind = 2'(kind); req_src = 2'(src); req_addr = 2'(a); req_data = 8'(d);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    expect_msgs(a, stall);
  endtask

  task automatic do_rsp(input int a, input int d);
    q_n = 0;
    push(0, m_preq[a], d & 8'hFF, m_pwr[a] != 0 ? "R7 forward" : "R6 forward");
    m_mem[a] = d & 8'hFF; m_busy[a] = 0;
    if (m_pwr[a] != 0) begin m_st[a] = 2; m_sh[a] = 1 << m_preq[a]; end
    else               begin m_st[a] = 1; m_sh[a] = m_sh[a] | (1 << m_preq[a]); end
    rsp_addr = 2'(a); rsp_data = 8'(d); rsp_valid = 1'b1;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
    expect_msgs(a, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    for (int b = 0; b < BLOCKS; b++) begin
      m_st[b] = 0; m_sh[b] = 0; m_mem[b] = (3 * b + 1) & 8'hFF;
      m_busy[b] = 0; m_preq[b] = 0; m_pwr[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(!msg_valid, "R1 msg_valid after reset", int'(msg_valid), 0);
    chk(req_ready && rsp_ready, "R1 ready after reset", int'({req_ready, rsp_ready}), 3);
    // R1 R2 initial memory per block, read by node 0
    for (int b = 0; b < BLOCKS; b++) do_req(0, 0, b, 0, 0);
    // block 1: sharers {0,2}; write by 2 invalidates only 0 (R5)
    do_req(0, 2, 1, 0, 0);
    do_req(1, 2, 1, 0, 3);              // R10 back-pressure on the invalidate
    do_req(0, 3, 1, 0, 0);              // R6 fetch to owner 2
    do_req(0, 1, 1, 0, 0);              // R9 retry while busy
    do_req(2, 2, 1, 8'h44, 0);          // R9 write-back to busy block retried
    do_rsp(1, 8'h77);                   // R6 forward, sharers {2,3}
    do_req(1, 0, 1, 0, 0);              // R11 invalidates 2 then 3, data 77
    do_req(1, 1, 1, 0, 0);              // R7 fetch-invalidate to 0
    do_rsp(1, 8'h99);
    do_req(2, 2, 1, 8'h11, 0);          // R8 non-owner write-back ignored
    do_req(3, 1, 1, 8'h12, 0);          // R8 kind 3 ignored
    do_req(0, 0, 1, 0, 0);              // still exclusive: fetch to 1
    do_rsp(1, 8'h5C);
    do_req(1, 0, 1, 0, 0);              // invalidate 1, data 5C
    do_req(2, 0, 1, 8'h33, 0);          // R8 owner write-back
    do_req(0, 3, 1, 0, 0);              // R8 reply carries 33, sharer {3}
    do_req(1, 2, 2, 0, 0);              // R3 after prior read by 0: R5 path
    do_req(1, 1, 3, 0, 0);
    // near-exhaustive pseudo-ordered sweep
    for (int it = 0; it < 600; it++) begin
      int a = it % BLOCKS;
      int src = (it * 7 / 4 + it / 16) % NODES;
      int kind = (it * 5 / 3 + it / 20) % 4;
      if (m_busy[a] != 0 && (it % 3) != 0) do_rsp(a, (it * 37) ^ 8'h5A);
      else begin
        if (m_st[a] == 2 && m_sh[a] == (1 << src) && kind < 2) src = (src + 1) % NODES;
        do_req(kind, src, a, (it * 13 + 5) & 8'hFF, (it % 29 == 0) ? 2 : 0);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule